// File: doc/BRIEF.md
# Address-Space Root Switch Unit

This unit computes the next value of a 64-bit page-table root register when execution moves between the privileged and unprivileged address spaces. The two top-level directories of a process share one 8 KB-aligned region, so the move is a single bit flip in the root value. When address-space tags are enabled, the tag is also moved between its privileged and unprivileged versions by flipping one bit.

On a return to user space, a per-tag pending-flush bitmap decides whether the TLB entries for that tag must be discarded. If the tag's pending bit is set, the bit is consumed and the root is written with the no-invalidate flag clear, so the tag's entries are discarded. If the pending bit is clear, the root is written with the no-invalidate flag set. A separate request port marks tags as pending. The new value is registered and comes out with a one-cycle write strobe.

Top module: `asroot_switch`

## Requirements
- R1: One clock after a cycle with `enter_req` or `exit_req` high, `new_root` holds the computed value and `root_we` is high for exactly that one cycle. After a cycle with no request, `root_we` is low and `new_root` keeps its value.
- R2: On entry with `iso_en`=1, the output is `cur_root` with bits 12, 11 and 63 cleared. All other bits are kept.
- R3: On exit with `iso_en`=1 and `tag_en`=1, bits 12 and 11 of the output are set, and bits 10..0 keep the incoming tag.
- R4: On exit with `iso_en`=1 and `tag_en`=1, the bitmap index is `cur_root[10:0]`. If that pending bit is set, output bit 63 is 0 and the bit is cleared, so a second exit on the same tag sets bit 63.
- R5: On exit with `iso_en`=1 and `tag_en`=1, if the indexed pending bit is clear, output bit 63 is 1.
- R6: On exit with `iso_en`=1 and `tag_en`=0, only bit 12 is set. Bit 63 and bits 11..0 are passed through unchanged, and the bitmap is not touched.
- R7: With `iso_en`=0, every request writes `cur_root` back unchanged, still with a strobe, and leaves the bitmap alone.
- R8: `pend_set_vld` sets the pending bit of `pend_set_tag`. When it targets the tag that an exit clears in the same cycle, the bit ends up set.
- R9: If `enter_req` and `exit_req` are high together, the entry result is written and the bitmap is not cleared.
- R10: After reset, `new_root` is 0, `root_we` is 0 and every pending bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_en | input | 1 | Address-space isolation enable |
| tag_en | input | 1 | Address-space tag feature enable |
| cur_root | input | 64 | Current root register value |
| enter_req | input | 1 | Switch to the privileged space |
| exit_req | input | 1 | Switch to the unprivileged space |
| pend_set_vld | input | 1 | Mark a tag as pending flush |
| pend_set_tag | input | 11 | Tag index to mark |
| new_root | output | 64 | Registered new root value |
| root_we | output | 1 | One-cycle write strobe for `new_root` |

## Verification
The checker enforces the following on every cycle:
- the strobe timing;
- the bit-level shape of entry, tagged exit, untagged exit and bypassed results;
- that an idle cycle leaves the output stable.

Whether bit 63 is right on a tagged exit depends on the bitmap's history, so only the bench scenarios can show it. Those scenarios cover:
- a marked tag being consumed by one exit and not by the next;
- a set and a clear on the same tag in the same cycle;
- a combined request that leaves a pending mark in place;
- a tag index taken from a root that already carries the user bit.

// File: rtl/asroot_switch.sv
module asroot_switch #(
  parameter int ROOT_W    = 64,
  parameter int IDX_W     = 11,
  parameter int DIR_BIT   = 12,
  parameter int NOINV_BIT = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iso_en,
  input  logic              tag_en,
  input  logic [ROOT_W-1:0] cur_root,
  input  logic              enter_req,
  input  logic              exit_req,
  input  logic              pend_set_vld,
  input  logic [IDX_W-1:0]  pend_set_tag,
  output logic [ROOT_W-1:0] new_root,
  output logic              root_we
);
  localparam int DEPTH    = 1 << IDX_W;
  localparam int USER_BIT = IDX_W;

  logic [DEPTH-1:0]  pend, pend_nxt;
  logic [ROOT_W-1:0] root_nxt;

  wire [IDX_W-1:0] idx     = cur_root[IDX_W-1:0];
  wire             any_req = enter_req | exit_req;
  wire             do_ent  = iso_en & enter_req;
  wire             do_ext  = iso_en & exit_req & ~enter_req;
  wire             tag_ext = do_ext & tag_en;
  wire             hit     = pend[idx];

  always_comb begin
    root_nxt = cur_root;
    if (do_ent) begin
      root_nxt[DIR_BIT]   = 1'b0;
      root_nxt[USER_BIT]  = 1'b0;
      root_nxt[NOINV_BIT] = 1'b0;
    end else if (do_ext) begin
      root_nxt[DIR_BIT] = 1'b1;
      if (tag_en) begin
        root_nxt[USER_BIT]  = 1'b1;
        root_nxt[NOINV_BIT] = ~hit;
      end
    end
  end

  always_comb begin
    pend_nxt = pend;
    if (tag_ext && hit) pend_nxt[idx] = 1'b0;
    if (pend_set_vld)   pend_nxt[pend_set_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      new_root <= '0;
      root_we  <= 1'b0;
    end else begin
      pend    <= pend_nxt;
      root_we <= any_req;
      if (any_req) new_root <= root_nxt;
    end
  end
endmodule

// File: rtl/asroot_switch_chk.sv
module asroot_switch_chk #(
  parameter int ROOT_W = 64,
  parameter int IDX_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iso_en,
  input logic              tag_en,
  input logic [ROOT_W-1:0] cur_root,
  input logic              enter_req,
  input logic              exit_req,
  input logic [ROOT_W-1:0] new_root,
  input logic              root_we
);
  wire req = enter_req | exit_req;

  a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> root_we);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!root_we && $stable(new_root)));
  a_r2_entry_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && iso_en) |=>
      (!new_root[12] && !new_root[11] && !new_root[63] &&
       new_root[62:13] == $past(cur_root[62:13]) &&
       new_root[10:0] == $past(cur_root[10:0])));
  a_r3_exit_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && !enter_req && iso_en && tag_en) |=>
      (new_root[12] && new_root[11] &&
       new_root[10:0] == $past(cur_root[10:0])));
  a_r6_exit_untagged: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && !enter_req && iso_en && !tag_en) |=>
      (new_root[12] && new_root[63] == $past(cur_root[63]) &&
       new_root[11:0] == $past(cur_root[11:0])));
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !iso_en) |=> (new_root == $past(cur_root)));
endmodule

bind asroot_switch asroot_switch_chk #(.ROOT_W(ROOT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iso_en(iso_en), .tag_en(tag_en),
  .cur_root(cur_root), .enter_req(enter_req), .exit_req(exit_req),
  .new_root(new_root), .root_we(root_we)
);

// File: tb/tb_asroot_switch.sv
module tb_asroot_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iso_en = 1'b0, tag_en = 1'b0;
  logic [63:0] cur_root = '0;
  logic        enter_req = 1'b0, exit_req = 1'b0;
  logic        pend_set_vld = 1'b0;
  logic [10:0] pend_set_tag = '0;
  logic [63:0] new_root;
  logic        root_we;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  asroot_switch dut (
    .clk(clk), .rst_n(rst_n), .iso_en(iso_en), .tag_en(tag_en),
    .cur_root(cur_root), .enter_req(enter_req), .exit_req(exit_req),
    .pend_set_vld(pend_set_vld), .pend_set_tag(pend_set_tag),
    .new_root(new_root), .root_we(root_we)
  );

  // {op(1 enter,2 exit,3 both), iso, tag, root, expected}
  localparam logic [131:0] VEC [9] = '{
    {2'd1, 1'b1, 1'b1, 64'h0000_0000_1234_5803, 64'h0000_0000_1234_4003}, // R2
    {2'd1, 1'b1, 1'b1, 64'h8000_0000_ABCD_F805, 64'h0000_0000_ABCD_E005}, // R2
    {2'd2, 1'b1, 1'b1, 64'h0000_0000_1234_4002, 64'h8000_0000_1234_5802}, // R3 R5 R10
    {2'd2, 1'b1, 1'b0, 64'h0000_0000_5678_0000, 64'h0000_0000_5678_1000}, // R6
    {2'd2, 1'b0, 1'b1, 64'h0000_0000_1111_2003, 64'h0000_0000_1111_2003}, // R7
    {2'd1, 1'b0, 1'b1, 64'h8000_0000_2222_3801, 64'h8000_0000_2222_3801}, // R7
    {2'd3, 1'b1, 1'b1, 64'h0000_0000_3333_5806, 64'h0000_0000_3333_4006}, // R9
    {2'd1, 1'b1, 1'b0, 64'h0000_0000_4444_1000, 64'h0000_0000_4444_0000}, // R2
    {2'd2, 1'b1, 1'b0, 64'h8000_0000_5555_0000, 64'h8000_0000_5555_1000}  // R6
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic [1:0] kind, logic iso, logic tg, logic [63:0] root);
    @(negedge clk);
    iso_en = iso; tag_en = tg; cur_root = root;
    enter_req = kind[0]; exit_req = kind[1];
    @(negedge clk);
    enter_req = 1'b0; exit_req = 1'b0;
  endtask

  task automatic mark(logic [10:0] t);
    @(negedge clk);
    pend_set_vld = 1'b1; pend_set_tag = t;
    @(negedge clk);
    pend_set_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset root", new_root, 64'h0);
    check("R10 reset strobe", {63'h0, root_we}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      op(VEC[i][131:130], VEC[i][129], VEC[i][128], VEC[i][127:64]);
      check($sformatf("R1 strobe vec%0d", i), {63'h0, root_we}, 64'h1);
      check($sformatf("R2-table vec%0d", i), new_root, VEC[i][63:0]);
    end

    @(negedge clk);
    check("R1 strobe drops", {63'h0, root_we}, 64'h0);
    check("R1 hold value", new_root, VEC[8][63:0]);

    // R4: a marked tag is consumed once; index taken from root[10:0]
    mark(11'd3);
    op(2'd2, 1'b1, 1'b1, 64'h0000_0000_0000_0803);
    check("R4 flush on pending", new_root, 64'h0000_0000_0000_1803);
    op(2'd2, 1'b1, 1'b1, 64'h0000_0000_0000_0003);
    check("R4 pending consumed", new_root, 64'h8000_0000_0000_1803);

    // R8: a set and a clear on the same tag in the same cycle leave it set
    mark(11'd5);
    @(negedge clk);
    iso_en = 1'b1; tag_en = 1'b1; cur_root = 64'h5;
    exit_req = 1'b1; pend_set_vld = 1'b1; pend_set_tag = 11'd5;
    @(negedge clk);
    exit_req = 1'b0; pend_set_vld = 1'b0;
    check("R8 flush on collision", new_root, 64'h0000_0000_0000_1805);
    op(2'd2, 1'b1, 1'b1, 64'h5);
    check("R8 set wins", new_root, 64'h0000_0000_0000_1805);

    // R9: a combined request does not consume the pending bit
    mark(11'd6);
    op(2'd3, 1'b1, 1'b1, 64'h0000_0000_0000_1806);
    check("R9 entry wins", new_root, 64'h0000_0000_0000_0006);
    op(2'd2, 1'b1, 1'b1, 64'h6);
    check("R9 pending kept", new_root, 64'h0000_0000_0000_1806);

    // R6 and R7 leave the bitmap alone
    mark(11'd2);
    op(2'd2, 1'b1, 1'b0, 64'h2);
    op(2'd2, 1'b0, 1'b1, 64'h2);
    op(2'd2, 1'b1, 1'b1, 64'h2);
    check("R6 R7 bitmap untouched", new_root, 64'h0000_0000_0000_1802);

    // R10: reset clears the bitmap
    mark(11'd7);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset root again", new_root, 64'h0);
    rst_n = 1'b1;
    op(2'd2, 1'b1, 1'b1, 64'h7);
    check("R10 bitmap cleared", new_root, 64'h8000_0000_0000_1807);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule